// File: doc/BRIEF.md
# MSI-X Doorbell Interrupt Message Generator

This block turns a set of outbound doorbell interrupt lines into memory-write interrupt messages for a host. A host-programmed vector table holds one entry per doorbell line. Each entry has a low address word, a high address word, a data word and a vector-control word whose bit 0 masks the entry. A rising edge on a doorbell line marks the entry as pending. The block then issues a write request on a valid/ready port. The request carries the 64-bit address, the data word and a flag that asks for a full 64-bit (dual address cycle) transaction.

A control register enables message delivery and holds two more controls. One is a function-wide mask. The other is a single-vector mode that routes every doorbell through entry 0. While message delivery is disabled, the doorbells drive a wired interrupt output instead. Any host write into the table sets a local status bit, and that bit raises a local interrupt when its mask is clear.

The register port uses a flat word address. Entry `i`, field `f` sits at address `4*i + f`, with f = 0 for the low address, 1 for the high address, 2 for data and 3 for vector control. The control registers start at `4*NUM_VEC`, which is 32 by default: +0 control, +1 pending array, +2 local status, +3 local mask, +4 table size.

Top module: `msix_doorbell_gen`

## Requirements
- R1: After reset, no request is valid, the wired and local interrupts are low, the control register, pending array and local status read 0, and every entry's vector control and the local mask read 1.
- R2: Table fields read back as written. Address and data fields keep all 32 bits. Vector control keeps only bit 0 (the mask) and reads its other bits as 0.
- R3: The table size register at offset +4 reads the number of entries, which is 8.
- R4: With delivery enabled (control bit 0), a rising edge on doorbell line k sets pending bit k, visible on the clock after the edge is sampled. While entry k's mask bit is 1, no request is issued and the bit stays set.
- R5: An eligible pending entry raises `req_valid_o` one clock after its pending bit is set. The address is {high, low} of the entry and the data is the entry's data word.
- R6: `req_dac_o` is 1 exactly when the issued entry's high address word is non-zero.
- R7: A request holds its address, data and flag stable until `req_ready_i` is sampled high. The pending bit clears on that acknowledge, not earlier, and `req_valid_o` drops on the following clock.
- R8: When several entries are pending and eligible, they are issued one per request in ascending index order.
- R9: With single-vector mode on (control bit 2), any doorbell edge sets pending bit 0 only, and the message uses entry 0's fields.
- R10: With the function mask on (control bit 1), no new request starts, and pending bits are kept until the mask is cleared.
- R11: With delivery disabled, `wired_irq_o` follows the OR of the doorbell lines one clock later, and no pending bit is set. With delivery enabled, `wired_irq_o` stays low.
- R12: Any write into the table sets local status bit 0. Writing a 1 to that bit clears it, and writing a 0 leaves it set. `local_irq_o` is high when the status bit is 1 and the local mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| doorbell_i | input | 8 | Doorbell interrupt lines, one per table entry |
| req_valid_o | output | 1 | Message write request valid |
| req_ready_i | input | 1 | Message write request accepted |
| req_addr_o | output | 64 | Message address |
| req_data_o | output | 32 | Message data |
| req_dac_o | output | 1 | Issue as a 64-bit address transaction |
| wired_irq_o | output | 1 | Wired interrupt, used when message delivery is off |
| local_irq_o | output | 1 | Table-write interrupt to the local controller |

## Verification
The bench fills every entry so that the odd entries have non-zero high address words, then lets all eight entries go pending together behind the function mask. Releasing the mask shows whether requests come out in ascending order with the right 64-bit flag. A design that cleared pending bits at launch would lose a message whenever the host stalls. The bench therefore holds `req_ready_i` low and checks that both the request fields and the pending bit stay put. The bench also checks the exact latency from a doorbell edge to pending and then to a valid request, and the collapse of a high-index doorbell onto entry 0. Two more checks cover the write-one-to-clear status, which a wrong design could clear on any write, and a wired pin that must stay quiet while message delivery is on.

// File: rtl/msix_gen_pkg.sv
package msix_gen_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_VCTRL   = 2'd3
  } fld_e;

  typedef enum logic [2:0] {
    CREG_CTRL  = 3'd0,
    CREG_PEND  = 3'd1,
    CREG_LSTAT = 3'd2,
    CREG_LMASK = 3'd3,
    CREG_SIZE  = 3'd4
  } creg_e;

  typedef struct packed {
    logic [WORD_W-1:0] addr_lo;
    logic [WORD_W-1:0] addr_hi;
    logic [WORD_W-1:0] data;
    logic              masked;
  } vec_entry_t;

  typedef struct packed {
    logic single_vec;
    logic fn_mask;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_gen_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  fld_e              fld_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output vec_entry_t        entry_o [NUM_VEC]
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic hit;
    assign hit = wr_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_o[g].addr_lo <= '0;
        entry_o[g].addr_hi <= '0;
        entry_o[g].data    <= '0;
        entry_o[g].masked  <= 1'b1;
      end else if (hit) begin
        unique case (fld_i)
          FLD_ADDR_LO: entry_o[g].addr_lo <= wdata_i;
          FLD_ADDR_HI: entry_o[g].addr_hi <= wdata_i;
          FLD_DATA:    entry_o[g].data    <= wdata_i;
          FLD_VCTRL:   entry_o[g].masked  <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (fld_i)
      FLD_ADDR_LO: rdata_o = entry_o[idx_i].addr_lo;
      FLD_ADDR_HI: rdata_o = entry_o[idx_i].addr_hi;
      FLD_DATA:    rdata_o = entry_o[idx_i].data;
      default:     rdata_o = {{(WORD_W-1){1'b0}}, entry_o[idx_i].masked};
    endcase
  end
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  input  logic [NUM_VEC-1:0] elig_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic               gnt_vld_o,
  output logic [IDX_W-1:0]   gnt_idx_o
);
  // set wins over clear: a new edge during the ack needs another message
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;
  end

  logic [NUM_VEC-1:0] req;
  assign req = pend_o & elig_i;

  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msix_doorbell_gen.sv
module msix_doorbell_gen
  import msix_gen_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,  // >= 4, power of two
  localparam int unsigned IDX_W  = $clog2(NUM_VEC),
  localparam int unsigned TBL_W  = IDX_W + 2,
  localparam int unsigned ADDR_W = TBL_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  input  logic [NUM_VEC-1:0]  doorbell_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [2*WORD_W-1:0] req_addr_o,
  output logic [WORD_W-1:0]   req_data_o,
  output logic                req_dac_o,
  output logic                wired_irq_o,
  output logic                local_irq_o
);
  // register decode
  logic tbl_sel, creg_sel, tbl_we;
  creg_e creg;
  assign tbl_sel  = !reg_addr_i[ADDR_W-1];
  assign creg_sel = reg_addr_i[ADDR_W-1] && (reg_addr_i[TBL_W-1:3] == '0);
  assign creg     = creg_e'(reg_addr_i[2:0]);
  assign tbl_we   = reg_we_i && tbl_sel;

  logic [WORD_W-1:0] tbl_rdata;
  vec_entry_t        entry [NUM_VEC];

  msix_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (tbl_we),
    .idx_i   (reg_addr_i[TBL_W-1:2]),
    .fld_i   (fld_e'(reg_addr_i[1:0])),
    .wdata_i (reg_wdata_i),
    .rdata_o (tbl_rdata),
    .entry_o (entry)
  );

  // control, local status and mask
  ctrl_t ctrl_q;
  logic  lstat_q, lmask_q;
  logic  msix_en, fn_mask;
  assign msix_en = ctrl_q.enable;
  assign fn_mask = ctrl_q.fn_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      lstat_q <= 1'b0;
      lmask_q <= 1'b1;
    end else begin
      if (reg_we_i && creg_sel && creg == CREG_CTRL)  ctrl_q  <= ctrl_t'(reg_wdata_i[2:0]);
      if (reg_we_i && creg_sel && creg == CREG_LMASK) lmask_q <= reg_wdata_i[0];
      if (tbl_we)                                     lstat_q <= 1'b1;
      else if (reg_we_i && creg_sel && creg == CREG_LSTAT && reg_wdata_i[0])
                                                      lstat_q <= 1'b0;
    end
  end
  assign local_irq_o = lstat_q && !lmask_q;

  // doorbell edge detect and wired path
  logic [NUM_VEC-1:0] db_q, rise, set_vec;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q        <= '0;
      wired_irq_o <= 1'b0;
    end else begin
      db_q        <= doorbell_i;
      wired_irq_o <= !msix_en && (|doorbell_i);
    end
  end
  assign rise = doorbell_i & ~db_q;

  always_comb begin
    if (!msix_en)               set_vec = '0;
    else if (ctrl_q.single_vec) set_vec = {{(NUM_VEC-1){1'b0}}, |rise};
    else                        set_vec = rise;
  end

  logic [NUM_VEC-1:0] elig;
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_elig
    assign elig[g] = msix_en && !fn_mask && !entry[g].masked;
  end

  // request launcher
  logic               busy_q;
  logic [IDX_W-1:0]   cur_q;
  logic [NUM_VEC-1:0] pend, clr_vec;
  logic               gnt_vld;
  logic [IDX_W-1:0]   gnt_idx;

  assign clr_vec = (busy_q && req_ready_i) ? (NUM_VEC'(1) << cur_q) : '0;

  msix_pend_arb #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .elig_i    (elig),
    .pend_o    (pend),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cur_q      <= '0;
      req_addr_o <= '0;
      req_data_o <= '0;
      req_dac_o  <= 1'b0;
    end else if (!busy_q) begin
      if (gnt_vld) begin
        busy_q     <= 1'b1;
        cur_q      <= gnt_idx;
        req_addr_o <= {entry[gnt_idx].addr_hi, entry[gnt_idx].addr_lo};
        req_data_o <= entry[gnt_idx].data;
        req_dac_o  <= (entry[gnt_idx].addr_hi != '0);
      end
    end else if (req_ready_i) begin
      busy_q <= 1'b0;
    end
  end
  assign req_valid_o = busy_q;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (tbl_sel) reg_rdata_o = tbl_rdata;
    else if (creg_sel) begin
      unique case (creg)
        CREG_CTRL:  reg_rdata_o = WORD_W'(ctrl_q);
        CREG_PEND:  reg_rdata_o = WORD_W'(pend);
        CREG_LSTAT: reg_rdata_o = WORD_W'(lstat_q);
        CREG_LMASK: reg_rdata_o = WORD_W'(lmask_q);
        CREG_SIZE:  reg_rdata_o = WORD_W'(NUM_VEC);
        default:    reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/msix_doorbell_gen_chk.sv
module msix_doorbell_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        req_valid_o,
  input logic        req_ready_i,
  input logic [63:0] req_addr_o,
  input logic [31:0] req_data_o,
  input logic        req_dac_o,
  input logic        wired_irq_o,
  input logic        local_irq_o,
  input logic        msix_en,
  input logic        fn_mask
);
  assert_req_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_data_o) && $stable(req_dac_o));

  assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);

  assert_dac_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_dac_o == (req_addr_o[63:32] != '0)));

  assert_fn_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_mask && !req_valid_o |=> !req_valid_o);

  assert_wired_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_en |=> !wired_irq_o);

  assert_local_irq_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(local_irq_o) |-> $past(reg_we_i));
endmodule

bind msix_doorbell_gen msix_doorbell_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_data_o  (req_data_o),
  .req_dac_o   (req_dac_o),
  .wired_irq_o (wired_irq_o),
  .local_irq_o (local_irq_o),
  .msix_en     (msix_en),
  .fn_mask     (fn_mask)
);

// File: tb/msix_doorbell_gen_tb_top.sv
module msix_doorbell_gen_tb_top;
  localparam int N = 8;
  localparam logic [5:0] A_CTRL = 6'd32, A_PEND = 6'd33, A_LSTAT = 6'd34, A_LMASK = 6'd35, A_SIZE = 6'd36;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, ready = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] db = '0;
  logic        valid, dac, wired, lirq;
  logic [63:0] raddr;
  logic [31:0] rqdata;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  msix_doorbell_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .doorbell_i(db),
    .req_valid_o(valid), .req_ready_i(ready), .req_addr_o(raddr),
    .req_data_o(rqdata), .req_dac_o(dac), .wired_irq_o(wired), .local_irq_o(lirq)
  );

  function automatic logic [31:0] lo_of(int i); return 32'h1000_0000 + 32'(i) * 32'h40; endfunction
  function automatic logic [31:0] hi_of(int i); return (i % 2 == 1) ? 32'h0000_0100 + 32'(i) : 32'h0; endfunction
  function automatic logic [31:0] dat_of(int i); return 32'hD000_0000 + 32'(i); endfunction
  function automatic logic [5:0] ta(int i, int f); return 6'(i * 4 + f); endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; write lands at the next posedge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_valid();
    for (int t = 0; t < 6 && !valid; t++) @(negedge clk);
  endtask

  task automatic ack();
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk("R7 valid drops after ack", valid, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 valid", valid, 0);
    chk("R1 wired", wired, 0);
    chk("R1 local irq", lirq, 0);
    for (int i = 0; i < N; i++) begin rd(ta(i, 3), v); chk("R1 vctrl masked", v, 1); end
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_PEND, v);  chk("R1 pend", v, 0);
    rd(A_LSTAT, v); chk("R1 lstat", v, 0);
    rd(A_LMASK, v); chk("R1 lmask", v, 1);

    // R3 table size
    rd(A_SIZE, v); chk("R3 size", v, N);

    // R2 fill and read back
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr(ta(i, 0), lo_of(i));
      wr(ta(i, 1), hi_of(i));
      wr(ta(i, 2), dat_of(i));
      wr(ta(i, 3), 32'hFFFF_FFFF);
    end
    for (int i = 0; i < N; i++) begin
      rd(ta(i, 0), v); chk("R2 addr lo", v, lo_of(i));
      rd(ta(i, 1), v); chk("R2 addr hi", v, hi_of(i));
      rd(ta(i, 2), v); chk("R2 data", v, dat_of(i));
      rd(ta(i, 3), v); chk("R2 vctrl bit0 only", v, 1);
    end

    // R12 local status / mask
    rd(A_LSTAT, v); chk("R12 status set by table write", v, 1);
    chk("R12 irq masked", lirq, 0);
    @(negedge clk); wr(A_LMASK, 0);
    chk("R12 irq unmasked", lirq, 1);
    wr(A_LSTAT, 0);
    rd(A_LSTAT, v); chk("R12 write 0 keeps status", v, 1);
    @(negedge clk); wr(A_LSTAT, 1);
    chk("R12 W1C clears irq", lirq, 0);
    wr(ta(4, 2), dat_of(4));
    chk("R12 table write re-raises", lirq, 1);
    wr(A_LSTAT, 1);
    chk("R12 cleared again", lirq, 0);

    // R11 wired path with delivery off
    db[3] = 1'b1;
    @(negedge clk);
    chk("R11 wired follows doorbell", wired, 1);
    rd(A_PEND, v); chk("R11 no pending when off", v, 0);
    chk("R11 no request when off", valid, 0);
    db[3] = 1'b0;
    @(negedge clk);
    chk("R11 wired drops", wired, 0);

    // enable delivery, all entries masked
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < N; k++) begin
      db[k] = 1'b1;
      @(negedge clk);
      rd(A_PEND, v); chk("R4 pending set", 64'(v[k]), 1);
      chk("R11 wired quiet while enabled", wired, 0);
      db[k] = 1'b0;
      @(negedge clk);
      chk("R4 masked no request", valid, 0);
    end
    rd(A_PEND, v); chk("R4 all pending", v, 32'hFF);

    // R10 function mask holds everything
    @(negedge clk);
    wr(A_CTRL, 32'h3);
    for (int i = 0; i < N; i++) wr(ta(i, 3), 0);
    repeat (3) @(negedge clk);
    chk("R10 no request under function mask", valid, 0);
    rd(A_PEND, v); chk("R10 pending kept", v, 32'hFF);

    // R8 ascending drain, R6 flag, R7 hold
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < N; i++) begin
      wait_valid();
      chk("R8 order data", rqdata, dat_of(i));
      chk("R5 address", raddr, {hi_of(i), lo_of(i)});
      chk("R6 dac flag", dac, (hi_of(i) != 0));
      @(negedge clk);
      chk("R7 held data", rqdata, dat_of(i));
      chk("R7 still valid", valid, 1);
      rd(A_PEND, v); chk("R7 pending until ack", 64'(v[i]), 1);
      ack();
      rd(A_PEND, v); chk("R7 pending cleared on ack", 64'(v[i]), 0);
    end

    // R5 exact latency
    db[5] = 1'b1;
    @(negedge clk);
    rd(A_PEND, v); chk("R5 pending after one clock", v, 32'h20);
    chk("R5 not yet valid", valid, 0);
    @(negedge clk);
    db[5] = 1'b0;
    chk("R5 valid one clock later", valid, 1);
    chk("R5 data", rqdata, dat_of(5));
    chk("R6 dac for odd entry", dac, 1);
    ack();

    // R9 single-vector collapse
    wr(A_CTRL, 32'h5);
    db[6] = 1'b1;
    @(negedge clk);
    rd(A_PEND, v); chk("R9 only bit 0 pending", v, 32'h1);
    @(negedge clk);
    db[6] = 1'b0;
    chk("R9 valid", valid, 1);
    chk("R9 entry 0 data", rqdata, dat_of(0));
    chk("R9 entry 0 address", raddr, {hi_of(0), lo_of(0)});
    chk("R6 dac off for zero high word", dac, 0);
    ack();
    rd(A_PEND, v); chk("R9 pending drained", v, 0);

    // R4 individual mask, then release
    wr(A_CTRL, 32'h1);
    wr(ta(2, 3), 1);
    db[2] = 1'b1;
    @(negedge clk);
    db[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 masked entry holds", valid, 0);
    rd(A_PEND, v); chk("R4 masked pending", v, 32'h4);
    wr(ta(2, 3), 0);
    wait_valid();
    chk("R4 released data", rqdata, dat_of(2));
    ack();
    rd(A_PEND, v); chk("R4 released pending clear", v, 0);

    finish_run();
  end
endmodule